// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Resolver

This block takes one interrupt command and works out which processors it reaches and what each of them receives. A command carries an 8-bit destination field, a physical/logical select, a 2-bit shorthand, a 3-bit delivery mode, a vector, and the level and trigger bits. The block also reads, for every processor, its 8-bit ID, its 8-bit logical destination and whether it uses the flat or the cluster logical model.

One cycle after a command-valid pulse, the block raises a done pulse. In that same cycle it presents the resolved one-bit-per-CPU destination mask and the per-CPU strobes for the delivery mode. The strobes are fixed request, SMI, NMI, INIT, startup and arbitration-ID reload, together with the vector and the trigger bit. All outputs are zero in every other cycle. The processor count is a parameter, 16 by default. Priority arbitration among processors and external-interrupt routing are left to other logic.

Top module: `ipi_dest_resolver`

## Requirements
- R1: After reset every output is zero: done, dest_mask, all strobe vectors, out_vector and out_trigger.
- R2: done and all strobes are registered. They appear in the cycle after cmd_valid and last exactly one cycle. In any cycle without done, dest_mask and every strobe are zero.
- R3: Shorthand code 0 resolves through the destination field. Code 1 selects the CPU whose ID equals sender_id. Code 2 selects every CPU. Code 3 selects every CPU except the one whose ID equals sender_id.
- R4: With cmd_logical = 0, a destination of 0xFF selects the CPUs at mask positions 0 to 7. Any other destination value selects the CPU whose ID equals it.
- R5: With cmd_logical = 1 and a CPU in the flat model (cpu_cluster bit 0), that CPU is selected when cmd_dest AND its logical destination is nonzero.
- R6: With cmd_logical = 1 and a CPU in the cluster model (cpu_cluster bit 1), that CPU is selected when two conditions hold. Bits [7:4] of cmd_dest and of its logical destination must be equal. Bits [3:0] of the two must share at least one set bit.
- R7: A CPU whose ID is NUM_CPU or larger is never set in dest_mask, under any shorthand or mode.
- R8: Delivery mode 3'b000 (fixed) sets fixed_req equal to dest_mask. out_vector carries the vector and out_trigger carries the trigger bit.
- R9: Delivery mode 3'b001 (lowest priority) sets fixed_req only for the lowest-indexed CPU in dest_mask. With an empty mask, no strobe is raised.
- R10: Delivery modes 3'b010 (SMI) and 3'b100 (NMI) set smi_req and nmi_req, respectively, equal to dest_mask.
- R11: Delivery mode 3'b101 (INIT) with cmd_level = 0 and cmd_trigger = 1 sets arb_reload equal to dest_mask and raises no init_req. Any other INIT sets init_req equal to dest_mask.
- R12: Delivery mode 3'b110 (startup) sets sipi_req equal to dest_mask, with the vector on out_vector.
- R13: Delivery modes 3'b111 (external interrupt) and 3'b011 (reserved) raise no strobe. done still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_dest | input | 8 | Destination field |
| cmd_logical | input | 1 | 0 physical, 1 logical destination |
| cmd_shorthand | input | 2 | Destination shorthand |
| cmd_dmode | input | 3 | Delivery mode |
| cmd_vector | input | 8 | Interrupt or startup vector |
| cmd_level | input | 1 | Level bit of the command |
| cmd_trigger | input | 1 | Trigger bit of the command (1 level) |
| sender_id | input | 8 | ID of the issuing CPU |
| cpu_id | input | NUM_CPU*8 | Per-CPU ID, CPU i at bits [8i+7:8i] |
| cpu_logdest | input | NUM_CPU*8 | Per-CPU logical destination |
| cpu_cluster | input | NUM_CPU | Per-CPU logical model, 1 cluster |
| done | output | 1 | Result valid pulse |
| dest_mask | output | NUM_CPU | Resolved destination set |
| fixed_req | output | NUM_CPU | Fixed-style vector request |
| out_vector | output | 8 | Vector for fixed and startup requests |
| out_trigger | output | 1 | Trigger mode for fixed requests |
| smi_req | output | NUM_CPU | SMI strobe |
| nmi_req | output | NUM_CPU | NMI strobe |
| init_req | output | NUM_CPU | INIT strobe |
| sipi_req | output | NUM_CPU | Startup strobe |
| arb_reload | output | NUM_CPU | Arbitration-ID reload strobe |

## Verification
The assertions take cmd_valid as a pulse whose command fields are stable on the clock edge that samples it. They also assume the per-CPU IDs do not change between that edge and the edge after it, and that no command arrives while the internal reset synchronizer is still releasing. The bench drives every command field and ID on the falling edge, holds cmd_valid for a single cycle, and waits several cycles after reset before its first command. Because of this, each result it samples on the next falling edge belongs to exactly one command.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int ID_W       = 8;
  localparam int DEST_W     = 8;
  localparam int VEC_W      = 8;
  localparam int BCAST_SPAN = 8;
  localparam logic [DEST_W-1:0] PHYS_BCAST = 8'hFF;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWEST = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSVD   = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_START  = 3'd6,
    DM_EXTINT = 3'd7
  } dmode_e;

  typedef enum logic [1:0] {
    SH_FIELD    = 2'd0,
    SH_SELF     = 2'd1,
    SH_ALL      = 2'd2,
    SH_ALL_BUT  = 2'd3
  } short_e;
endpackage

// File: rtl/ipi_cpu_match.sv
module ipi_cpu_match
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 16,
  parameter int IDX     = 0
) (
  input  logic [DEST_W-1:0] dest,
  input  logic              logical,
  input  logic [1:0]        shorthand,
  input  logic [ID_W-1:0]   sender_id,
  input  logic [ID_W-1:0]   my_id,
  input  logic [DEST_W-1:0] my_logdest,
  input  logic              my_cluster,
  output logic              hit
);
  localparam logic [ID_W:0] ID_LIMIT = (ID_W+1)'(NUM_CPU);
  localparam bit IN_SPAN = (IDX < BCAST_SPAN);

  logic id_ok, is_self, phys_hit, flat_hit, clus_hit, field_hit, sel;

  always_comb begin
    id_ok     = ({1'b0, my_id} < ID_LIMIT);
    is_self   = (my_id == sender_id);
    phys_hit  = (dest == PHYS_BCAST) ? IN_SPAN : (my_id == dest);
    flat_hit  = |(dest & my_logdest);
    clus_hit  = (dest[7:4] == my_logdest[7:4]) && (|(dest[3:0] & my_logdest[3:0]));
    field_hit = logical ? (my_cluster ? clus_hit : flat_hit) : phys_hit;
    unique case (short_e'(shorthand))
      SH_FIELD:   sel = field_hit;
      SH_SELF:    sel = is_self;
      SH_ALL:     sel = 1'b1;
      SH_ALL_BUT: sel = !is_self;
      default:    sel = 1'b0;
    endcase
    hit = id_ok && sel;
  end
endmodule

// File: rtl/ipi_lowest_pick.sv
module ipi_lowest_pick #(
  parameter int NUM_CPU = 16
) (
  input  logic [NUM_CPU-1:0] req,
  output logic [NUM_CPU-1:0] pick
);
  localparam logic [NUM_CPU-1:0] ONE = {{(NUM_CPU-1){1'b0}}, 1'b1};

  // Two's-complement isolate: keeps only the least significant set bit.
  assign pick = req & (~req + ONE);
endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 16
) (
  input  logic [NUM_CPU-1:0] mask,
  input  logic [NUM_CPU-1:0] lowest,
  input  logic [2:0]         dmode,
  input  logic               level,
  input  logic               trigger,
  output logic [NUM_CPU-1:0] fixed_v,
  output logic [NUM_CPU-1:0] smi_v,
  output logic [NUM_CPU-1:0] nmi_v,
  output logic [NUM_CPU-1:0] init_v,
  output logic [NUM_CPU-1:0] sipi_v,
  output logic [NUM_CPU-1:0] arb_v
);
  always_comb begin
    fixed_v = '0;
    smi_v   = '0;
    nmi_v   = '0;
    init_v  = '0;
    sipi_v  = '0;
    arb_v   = '0;
    unique case (dmode_e'(dmode))
      DM_FIXED:  fixed_v = mask;
      DM_LOWEST: fixed_v = lowest;
      DM_SMI:    smi_v   = mask;
      DM_NMI:    nmi_v   = mask;
      DM_INIT: begin
        // de-assert form only refreshes arbitration IDs
        if (!level && trigger) arb_v  = mask;
        else                   init_v = mask;
      end
      DM_START:  sipi_v  = mask;
      default: ;
    endcase
  end
endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [7:0]                cmd_dest,
  input  logic                      cmd_logical,
  input  logic [1:0]                cmd_shorthand,
  input  logic [2:0]                cmd_dmode,
  input  logic [7:0]                cmd_vector,
  input  logic                      cmd_level,
  input  logic                      cmd_trigger,
  input  logic [7:0]                sender_id,
  input  logic [NUM_CPU*8-1:0]      cpu_id,
  input  logic [NUM_CPU*8-1:0]      cpu_logdest,
  input  logic [NUM_CPU-1:0]        cpu_cluster,
  output logic                      done,
  output logic [NUM_CPU-1:0]        dest_mask,
  output logic [NUM_CPU-1:0]        fixed_req,
  output logic [7:0]                out_vector,
  output logic                      out_trigger,
  output logic [NUM_CPU-1:0]        smi_req,
  output logic [NUM_CPU-1:0]        nmi_req,
  output logic [NUM_CPU-1:0]        init_req,
  output logic [NUM_CPU-1:0]        sipi_req,
  output logic [NUM_CPU-1:0]        arb_reload
);
  // reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic [NUM_CPU-1:0] hit_mask, low_mask;
  logic [NUM_CPU-1:0] fx_c, smi_c, nmi_c, init_c, sipi_c, arb_c;

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
    ipi_cpu_match #(.NUM_CPU(NUM_CPU), .IDX(g)) match_i (
      .dest       (cmd_dest),
      .logical    (cmd_logical),
      .shorthand  (cmd_shorthand),
      .sender_id  (sender_id),
      .my_id      (cpu_id[g*ID_W +: ID_W]),
      .my_logdest (cpu_logdest[g*DEST_W +: DEST_W]),
      .my_cluster (cpu_cluster[g]),
      .hit        (hit_mask[g])
    );
  end

  ipi_lowest_pick #(.NUM_CPU(NUM_CPU)) pick_i (
    .req  (hit_mask),
    .pick (low_mask)
  );

  ipi_dispatch #(.NUM_CPU(NUM_CPU)) disp_i (
    .mask    (hit_mask),
    .lowest  (low_mask),
    .dmode   (cmd_dmode),
    .level   (cmd_level),
    .trigger (cmd_trigger),
    .fixed_v (fx_c),
    .smi_v   (smi_c),
    .nmi_v   (nmi_c),
    .init_v  (init_c),
    .sipi_v  (sipi_c),
    .arb_v   (arb_c)
  );

  // next-state
  logic               done_d, trig_d;
  logic [VEC_W-1:0]   vec_d;
  logic [NUM_CPU-1:0] mask_d, fx_d, smi_d, nmi_d, init_d, sipi_d, arb_d;

  always_comb begin
    done_d = cmd_valid;
    trig_d = cmd_valid ? cmd_trigger : 1'b0;
    vec_d  = cmd_valid ? cmd_vector  : '0;
    mask_d = cmd_valid ? hit_mask    : '0;
    fx_d   = cmd_valid ? fx_c        : '0;
    smi_d  = cmd_valid ? smi_c       : '0;
    nmi_d  = cmd_valid ? nmi_c       : '0;
    init_d = cmd_valid ? init_c      : '0;
    sipi_d = cmd_valid ? sipi_c      : '0;
    arb_d  = cmd_valid ? arb_c       : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      done        <= 1'b0;
      out_trigger <= 1'b0;
      out_vector  <= '0;
      dest_mask   <= '0;
      fixed_req   <= '0;
      smi_req     <= '0;
      nmi_req     <= '0;
      init_req    <= '0;
      sipi_req    <= '0;
      arb_reload  <= '0;
    end else begin
      done        <= done_d;
      out_trigger <= trig_d;
      out_vector  <= vec_d;
      dest_mask   <= mask_d;
      fixed_req   <= fx_d;
      smi_req     <= smi_d;
      nmi_req     <= nmi_d;
      init_req    <= init_d;
      sipi_req    <= sipi_d;
      arb_reload  <= arb_d;
    end
  end
endmodule

// File: rtl/ipi_dest_resolver_chk.sv
module ipi_dest_resolver_chk #(
  parameter int NUM_CPU = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic [2:0]           cmd_dmode,
  input logic                 cmd_level,
  input logic                 cmd_trigger,
  input logic [NUM_CPU*8-1:0] cpu_id,
  input logic                 done,
  input logic [NUM_CPU-1:0]   dest_mask,
  input logic [NUM_CPU-1:0]   fixed_req,
  input logic [NUM_CPU-1:0]   smi_req,
  input logic [NUM_CPU-1:0]   nmi_req,
  input logic [NUM_CPU-1:0]   init_req,
  input logic [NUM_CPU-1:0]   sipi_req,
  input logic [NUM_CPU-1:0]   arb_reload
);
  logic [NUM_CPU-1:0] bad_id;
  for (genvar g = 0; g < NUM_CPU; g++) begin : g_bad
    assign bad_id[g] = (32'(cpu_id[g*8 +: 8]) >= NUM_CPU);
  end

  logic [NUM_CPU-1:0] any_strobe;
  assign any_strobe = fixed_req | smi_req | nmi_req | init_req | sipi_req | arb_reload;

  p_done_follows_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> done);
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !done);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (dest_mask == '0 && any_strobe == '0));
  p_strobe_in_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((any_strobe & ~dest_mask) == '0));
  p_bad_id_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> ((dest_mask & $past(bad_id)) == '0));
  p_lowest_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_dmode == 3'd1) |=> ($onehot0(fixed_req) && ((dest_mask != '0) == (fixed_req != '0))));
  p_init_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_dmode == 3'd5 && !cmd_level && cmd_trigger) |=> (init_req == '0 && arb_reload == dest_mask));
  p_silent_modes_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_dmode == 3'd7 || cmd_dmode == 3'd3)) |=> (any_strobe == '0));
endmodule

bind ipi_dest_resolver ipi_dest_resolver_chk #(.NUM_CPU(NUM_CPU)) chk_i (.*);

// File: tb/ipi_dest_resolver_tb_top.sv
`timescale 1ns/1ps
module ipi_dest_resolver_tb_top;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_logical, cmd_level, cmd_trigger;
  logic [7:0] cmd_dest, cmd_vector, sender_id;
  logic [1:0] cmd_shorthand;
  logic [2:0] cmd_dmode;
  logic [N*8-1:0] cpu_id, cpu_logdest;
  logic [N-1:0] cpu_cluster;
  logic done, out_trigger;
  logic [7:0] out_vector;
  logic [N-1:0] dest_mask, fixed_req, smi_req, nmi_req, init_req, sipi_req, arb_reload;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ipi_dest_resolver #(.NUM_CPU(N)) dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_out(string tag, logic [N-1:0] m, logic [N-1:0] fx, logic [N-1:0] sm,
                            logic [N-1:0] nm, logic [N-1:0] in, logic [N-1:0] sp, logic [N-1:0] ar);
    chk({tag, " done"}, 32'(done), 32'd1);
    chk({tag, " mask"}, 32'(dest_mask), 32'(m));
    chk({tag, " fixed"}, 32'(fixed_req), 32'(fx));
    chk({tag, " smi"}, 32'(smi_req), 32'(sm));
    chk({tag, " nmi"}, 32'(nmi_req), 32'(nm));
    chk({tag, " init"}, 32'(init_req), 32'(in));
    chk({tag, " sipi"}, 32'(sipi_req), 32'(sp));
    chk({tag, " arb"}, 32'(arb_reload), 32'(ar));
  endtask

  // drive on falling edge, result registered at next rising edge, sampled at following falling edge
  task automatic issue(logic [7:0] d, logic lg, logic [1:0] sh, logic [2:0] dm,
                       logic [7:0] v, logic lv, logic tr, logic [7:0] snd);
    @(negedge clk);
    cmd_dest = d; cmd_logical = lg; cmd_shorthand = sh; cmd_dmode = dm;
    cmd_vector = v; cmd_level = lv; cmd_trigger = tr; sender_id = snd;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic cfg_flat();
    for (int i = 0; i < N; i++) begin
      cpu_id[i*8 +: 8] = 8'(i);
      cpu_logdest[i*8 +: 8] = 8'(1 << (i % 8));
      cpu_cluster[i] = 1'b0;
    end
  endtask

  task automatic cfg_cluster();
    for (int i = 0; i < N; i++) begin
      cpu_id[i*8 +: 8] = 8'(i);
      cpu_logdest[i*8 +: 8] = {4'(i / 4), 4'(1 << (i % 4))};
      cpu_cluster[i] = 1'b1;
    end
  endtask

  task automatic t_reset();
    chk("R1 done", 32'(done), 0);
    chk("R1 mask", 32'(dest_mask), 0);
    chk("R1 strobes", 32'(fixed_req | smi_req | nmi_req | init_req | sipi_req | arb_reload), 0);
    chk("R1 vector", 32'(out_vector), 0);
    chk("R1 trigger", 32'(out_trigger), 0);
  endtask

  task automatic t_phys_fixed();
    cfg_flat();
    issue(8'd5, 0, 2'd0, 3'd0, 8'h41, 0, 1, 8'd0);
    expect_out("R4 R8 phys fixed", 16'h0020, 16'h0020, 0, 0, 0, 0, 0);
    chk("R8 vector", 32'(out_vector), 32'h41);
    chk("R8 trigger", 32'(out_trigger), 1);
    @(negedge clk);
    chk("R2 done one cycle", 32'(done), 0);
    chk("R2 strobe one cycle", 32'(fixed_req | dest_mask), 0);
  endtask

  task automatic t_phys_bcast();
    cfg_flat();
    issue(8'hFF, 0, 2'd0, 3'd4, 8'h00, 0, 0, 8'd0);
    expect_out("R4 R10 bcast nmi", 16'h00FF, 0, 0, 16'h00FF, 0, 0, 0);
    issue(8'd20, 0, 2'd0, 3'd0, 8'h10, 0, 0, 8'd0);
    expect_out("R7 phys id absent", 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_bad_id();
    cfg_flat();
    cpu_id[3*8 +: 8] = 8'd40;
    issue(8'h00, 0, 2'd2, 3'd2, 8'h00, 0, 0, 8'd0);
    expect_out("R7 big id excluded", 16'hFFF7, 0, 16'hFFF7, 0, 0, 0, 0);
    cfg_flat();
  endtask

  task automatic t_shorthand();
    cfg_flat();
    issue(8'd9, 0, 2'd1, 3'd2, 8'h00, 0, 0, 8'd3);
    expect_out("R3 self", 16'h0008, 0, 16'h0008, 0, 0, 0, 0);
    issue(8'd9, 0, 2'd2, 3'd2, 8'h00, 0, 0, 8'd3);
    expect_out("R3 all", 16'hFFFF, 0, 16'hFFFF, 0, 0, 0, 0);
    issue(8'd9, 0, 2'd3, 3'd2, 8'h00, 0, 0, 8'd0);
    expect_out("R3 all but self", 16'hFFFE, 0, 16'hFFFE, 0, 0, 0, 0);
  endtask

  task automatic t_flat();
    cfg_flat();
    issue(8'h05, 1, 2'd0, 3'd0, 8'h22, 0, 0, 8'd0);
    expect_out("R5 flat", 16'h0505, 16'h0505, 0, 0, 0, 0, 0);
  endtask

  task automatic t_cluster();
    cfg_cluster();
    issue(8'h13, 1, 2'd0, 3'd0, 8'h23, 0, 0, 8'd0);
    expect_out("R6 cluster two", 16'h0030, 16'h0030, 0, 0, 0, 0, 0);
    issue(8'h18, 1, 2'd0, 3'd4, 8'h00, 0, 0, 8'd0);
    expect_out("R6 cluster one", 16'h0080, 0, 0, 16'h0080, 0, 0, 0);
    issue(8'h50, 1, 2'd0, 3'd0, 8'h00, 0, 0, 8'd0);
    expect_out("R6 cluster no low bits", 0, 0, 0, 0, 0, 0, 0);
    cfg_flat();
  endtask

  task automatic t_lowest();
    cfg_flat();
    issue(8'h0C, 1, 2'd0, 3'd1, 8'h31, 0, 0, 8'd0);
    expect_out("R9 lowest", 16'h0C0C, 16'h0004, 0, 0, 0, 0, 0);
    issue(8'd30, 0, 2'd0, 3'd1, 8'h31, 0, 0, 8'd0);
    expect_out("R9 lowest empty", 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_init();
    cfg_flat();
    issue(8'h00, 0, 2'd2, 3'd5, 8'h00, 0, 1, 8'd0);
    expect_out("R11 init deassert", 16'hFFFF, 0, 0, 0, 0, 0, 16'hFFFF);
    issue(8'h00, 0, 2'd2, 3'd5, 8'h00, 1, 1, 8'd0);
    expect_out("R11 init assert", 16'hFFFF, 0, 0, 0, 16'hFFFF, 0, 0);
  endtask

  task automatic t_sipi();
    cfg_flat();
    issue(8'd9, 0, 2'd0, 3'd6, 8'h9A, 0, 0, 8'd0);
    expect_out("R12 startup", 16'h0200, 0, 0, 0, 0, 16'h0200, 0);
    chk("R12 vector", 32'(out_vector), 32'h9A);
  endtask

  task automatic t_silent();
    cfg_flat();
    issue(8'h00, 0, 2'd2, 3'd7, 8'h11, 0, 0, 8'd0);
    expect_out("R13 extint", 16'hFFFF, 0, 0, 0, 0, 0, 0);
    issue(8'h00, 0, 2'd2, 3'd3, 8'h11, 0, 0, 8'd0);
    expect_out("R13 reserved", 16'hFFFF, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_dest = '0; cmd_logical = 0; cmd_shorthand = '0;
    cmd_dmode = '0; cmd_vector = '0; cmd_level = 0; cmd_trigger = 0; sender_id = '0;
    cpu_id = '0; cpu_logdest = '0; cpu_cluster = '0;
    cfg_flat();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_phys_fixed();
    t_phys_bcast();
    t_bad_id();
    t_shorthand();
    t_flat();
    t_cluster();
    t_lowest();
    t_init();
    t_sipi();
    t_silent();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule